// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CAS-Before-RAS Refresh

This block sits between a processor's memory-strobe bus and an asynchronous page-mode DRAM. The host asserts an active-low select together with a read or a write strobe and a word address. It also supplies a flag that tells the controller whether the access falls outside the currently open row. The controller drives the DRAM's active-low RAS, CAS and write-enable. It multiplexes the address so that the upper half goes out as the row and the lower half as the column. It raises a one-clock acknowledge when the access is done. The host holds its strobes and address steady until it sees that acknowledge, so the acknowledge is the host's only wait-state control.

A row stays open between accesses. A hit on the open row costs only a CAS pulse. A miss closes the row and opens the new one. An access that starts from idle always opens its row, whatever the page flag says, because RAS was released while the controller was idle.

A free-running interval timer raises a refresh request. The request stays set until the state machine reports that a CAS-before-RAS refresh cycle has finished. Refresh comes before any waiting access. A refresh that falls due during an access waits until that access has been acknowledged. An access that arrives during a refresh waits until the refresh is over.

Top module: `pmdram_ctrl`

## Requirements
- R1: The refresh timer counts 0 to REF_PERIOD-1 (default 621) and wraps. The refresh request is set at clock 621·k after reset release (clock 1 is the first rising edge with reset high). From idle, the refresh CAS fall follows the request by 3 clocks.
- R2: While reset is low, ras_n, cas_n and we_n are high and ack is low, at once and from any state.
- R3: A refresh lowers CAS while RAS is high. RAS falls exactly one clock later with CAS still low. we_n stays high. The request stays set until the controller signals that the refresh is complete.
- R4: An access from idle opens a row even when page_miss is 0. When RAS falls, dram_addr equals addr[21:11]. When CAS falls, dram_addr equals addr[10:0].
- R5: A read that hits the open row pulses only CAS: RAS does not fall again and we_n is high while CAS is low. ack is high for exactly one clock per access.
- R6: A write drives we_n low while CAS is low and puts addr[10:0] on dram_addr.
- R7: An access with page_miss=1 from an open row raises RAS and then lowers it again, with the new addr[21:11] as the row.
- R8: An access that arrives during a refresh gets no ack until the refresh has ended (RAS has risen).
- R9: With a row open and no request, RAS stays low and CAS stays high. A refresh that starts from an open row first holds RAS high for at least 3 sampled clocks, counting the clock in which CAS falls.
- R10: A refresh that falls due during an access waits for it to finish. If a hit read is captured at clock 621·k-1, ack comes at clock 621·k+1 and the refresh CAS falls at clock 621·k+5.
- R11: If a select is pending when a refresh ends, RAS falls for the new row exactly 3 clocks after the refresh RAS rises, without a pass through idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low memory select from host |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| page_miss | input | 1 | High when the access leaves the open row |
| addr | input | 22 | Word address; upper half is the row, lower half the column |
| ras_n | output | 1 | Active-low DRAM row strobe |
| cas_n | output | 1 | Active-low DRAM column strobe |
| we_n | output | 1 | Active-low DRAM write enable |
| dram_addr | output | 11 | Multiplexed row/column address |
| ack | output | 1 | One-clock access-complete pulse to the host |

## Verification
Accesses are driven from idle, as same-row reads and writes, as a page miss, and with no request at all. Counting RAS falls tells a full row open apart from a CAS-only hit, and the address captured at each strobe edge shows that the mux halves are correct. Refresh is placed in three positions relative to an access: on an idle bus, one clock before the request while an access is running, and with a select that arrives while the refresh is in progress. The exact clock numbers of ack, the refresh CAS fall and the reopening RAS fall show whether arbitration defers correctly and whether the controller skips idle. A reset in the middle of a row open checks that the strobes are forced high at once.

// File: rtl/pmdram_ctrl.sv
module pmdram_ctrl #(
  parameter int REF_PERIOD = 621,
  parameter int PRE_CYC    = 2,
  parameter int RCD_CYC    = 2,
  parameter int CAS_CYC    = 2,
  parameter int CBR_CYC    = 3,
  parameter int HALF_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic                  page_miss,
  input  logic [2*HALF_W-1:0]   addr,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic [HALF_W-1:0]     dram_addr,
  output logic                  ack
);

  localparam int TW = $clog2(REF_PERIOD);
  localparam int CW = $clog2(PRE_CYC + RCD_CYC + CAS_CYC + CBR_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RPRE, S_RCAS, S_RRAS, S_RDONE,
    S_ROWSET, S_ROWRAS, S_CAS, S_CASX, S_OPEN
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          rfq, rfc, mux_row;
  logic          tc, access;

  assign tc        = (tcnt == TW'(REF_PERIOD - 1));
  assign access    = !sel_n && (!rd_n || !wr_n);
  assign dram_addr = mux_row ? addr[2*HALF_W-1:HALF_W] : addr[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      rfq  <= 1'b0;
    end else begin
      tcnt <= tc ? '0 : tcnt + TW'(1);
      rfq  <= (rfq || tc) && !rfc;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mux_row <= 1'b0;
    else        mux_row <= (state == S_ROWSET) || (state == S_ROWRAS && cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ack   <= 1'b0;
      rfc   <= 1'b0;
    end else begin
      ack <= 1'b0;
      rfc <= 1'b0;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (rfq)         state <= S_RPRE;
          else if (!sel_n) state <= S_ROWSET;
        end
        S_RPRE: begin
          if (cnt == CW'(PRE_CYC - 1)) begin
            cas_n <= 1'b0;
            state <= S_RCAS;
          end else cnt <= cnt + CW'(1);
        end
        S_RCAS: begin
          ras_n <= 1'b0;
          cnt   <= '0;
          state <= S_RRAS;
        end
        S_RRAS: begin
          if (cnt == CW'(CBR_CYC - 1)) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            rfc   <= 1'b1;
            state <= S_RDONE;
          end else cnt <= cnt + CW'(1);
        end
        S_RDONE: begin
          cnt   <= '0;
          state <= !sel_n ? S_ROWSET : S_IDLE;
        end
        S_ROWSET: begin
          if (cnt == CW'(PRE_CYC - 1)) begin
            ras_n <= 1'b0;
            cnt   <= '0;
            state <= S_ROWRAS;
          end else cnt <= cnt + CW'(1);
        end
        S_ROWRAS: begin
          if (cnt == CW'(RCD_CYC - 1)) begin
            cnt <= '0;
            if (access) begin
              cas_n <= 1'b0;
              we_n  <= wr_n;
              state <= S_CAS;
            end else state <= S_OPEN;
          end else cnt <= cnt + CW'(1);
        end
        S_CAS: begin
          if (cnt == CW'(CAS_CYC - 1)) begin
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ack   <= 1'b1;
            state <= S_CASX;
          end else cnt <= cnt + CW'(1);
        end
        S_CASX: state <= S_OPEN;
        S_OPEN: begin
          cnt <= '0;
          if (rfq) begin
            ras_n <= 1'b1;
            state <= S_RPRE;
          end else if (!sel_n && page_miss) begin
            ras_n <= 1'b1;
            state <= S_ROWSET;
          end else if (access) begin
            cas_n <= 1'b0;
            we_n  <= wr_n;
            state <= S_CAS;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    rfq && !rfc |=> rfq);

  a_r3_ras_follows_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && ras_n |=> $fell(ras_n) && !cas_n && we_n);

  a_r4_row_on_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> dram_addr == addr[2*HALF_W-1:HALF_W]);

  a_r4_col_on_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> dram_addr == addr[HALF_W-1:0]);

  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r6_we_within_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n && !ras_n);

endmodule

// File: tb/pmdram_ctrl_test.sv
`timescale 1ns/100ps
module pmdram_ctrl_test;
  logic clk = 0, rst_n = 0, sel_n = 1, rd_n = 1, wr_n = 1, page_miss = 0;
  logic [21:0] addr = '0;
  logic ras_n, cas_n, we_n, ack;
  logic [10:0] dram_addr;

  pmdram_ctrl uut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .page_miss(page_miss), .addr(addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_addr(dram_addr), .ack(ack));

  always #2 clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic p_ras = 1, p_cas = 1, p_ack = 0;
  int ras_run = 0, cbr_n = 0, cbr_start = 0, cbr_end = 0, cbr_pre = 0;
  bit in_cbr = 0, cbr_ok = 0, cbr_we = 0, ack_wide = 0;
  int row_n = 0, row_cyc = 0, col_n = 0, ack_n = 0, ack_cyc = 0;
  int row_addr = 0, col_addr = 0, col_we = 0;

  always begin
    @(posedge clk); #1;
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_ack = 0; ras_run = 0; in_cbr = 0;
    end else begin
      if (ras_n) ras_run++; else ras_run = 0;
      if (p_cas && !cas_n) begin
        if (ras_n) begin
          cbr_n++; cbr_start = cyc; cbr_we = we_n; cbr_pre = ras_run; in_cbr = 1; cbr_ok = 0;
        end else begin
          col_n++; col_addr = int'(dram_addr); col_we = int'(we_n);
        end
      end
      if (p_ras && !ras_n) begin
        if (in_cbr) cbr_ok = (!cas_n && cyc == cbr_start + 1);
        else begin row_n++; row_cyc = cyc; row_addr = int'(dram_addr); end
      end
      if (!p_ras && ras_n && in_cbr) begin in_cbr = 0; cbr_end = cyc; end
      if (ack) begin if (p_ack) ack_wide = 1; ack_n++; ack_cyc = cyc; end
      p_ras = ras_n; p_cas = cas_n; p_ack = ack;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1.5;
  endtask

  task automatic host(bit wr, bit miss, logic [21:0] a, string req);
    int n0, t;
    @(negedge clk);
    addr = a; page_miss = miss; sel_n = 0;
    if (wr) wr_n = 0; else rd_n = 0;
    n0 = ack_n; t = 0;
    while (ack_n == n0 && t < 300) begin tick(); t++; end
    sel_n = 1; rd_n = 1; wr_n = 1; page_miss = 0;
    chk(ack_n == n0 + 1, req, ack_n - n0, 1);
  endtask

  task automatic wait_refresh();
    int c0 = cbr_n, t = 0;
    while (cbr_n == c0 && t < 1000) begin tick(); t++; end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) tick();
    chk({ras_n, cas_n, we_n, ack} == 4'b1110, "R2 reset outputs", int'({ras_n, cas_n, we_n, ack}), 14);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_first_refresh();
    wait_refresh();
    chk(cbr_start == 624, "R1 first refresh CAS fall clock", cbr_start, 624);
    repeat (2) tick();
    chk(cbr_ok, "R3 RAS one clock after CAS", int'(cbr_ok), 1);
    chk(cbr_we == 1, "R3 we_n high in refresh", int'(cbr_we), 1);
    repeat (8) tick();
  endtask

  task automatic t_idle_read();
    int r0 = row_n;
    host(0, 0, {11'h5A3, 11'h1C7}, "R4 idle read ack");
    chk(row_n == r0 + 1, "R4 row opened from idle", row_n - r0, 1);
    chk(row_addr == 'h5A3, "R4 row address", row_addr, 'h5A3);
    chk(col_addr == 'h1C7, "R4 column address", col_addr, 'h1C7);
    chk(col_we == 1, "R5 read we_n high", col_we, 1);
  endtask

  task automatic t_hit_write();
    int r0 = row_n;
    host(1, 0, {11'h5A3, 11'h02F}, "R6 hit write ack");
    chk(row_n == r0, "R5 hit write no RAS fall", row_n - r0, 0);
    chk(col_we == 0, "R6 write we_n low", col_we, 0);
    chk(col_addr == 'h02F, "R6 write column", col_addr, 'h02F);
  endtask

  task automatic t_hit_read();
    int r0 = row_n;
    host(0, 0, {11'h5A3, 11'h7FF}, "R5 hit read ack");
    chk(row_n == r0, "R5 hit read no RAS fall", row_n - r0, 0);
    chk(col_we == 1 && col_addr == 'h7FF, "R5 hit read column", col_addr, 'h7FF);
  endtask

  task automatic t_open_hold();
    int bad = 0;
    repeat (20) begin tick(); if (!(ras_n == 0 && cas_n == 1)) bad++; end
    chk(bad == 0, "R9 page held open", bad, 0);
  endtask

  task automatic t_miss_write();
    int r0 = row_n;
    host(1, 1, {11'h2B6, 11'h400}, "R7 miss write ack");
    chk(row_n == r0 + 1, "R7 row reopened", row_n - r0, 1);
    chk(row_addr == 'h2B6, "R7 new row address", row_addr, 'h2B6);
    chk(col_we == 0 && col_addr == 'h400, "R7 write column", col_addr, 'h400);
  endtask

  task automatic t_refresh_defer();
    int c0 = col_n;
    while (cyc < 1240) tick();
    host(0, 0, {11'h2B6, 11'h0AA}, "R10 access completes");
    chk(ack_cyc == 1243, "R10 ack clock", ack_cyc, 1243);
    chk(col_n == c0 + 1, "R10 access CAS pulse", col_n - c0, 1);
    wait_refresh();
    chk(cbr_start == 1247, "R10 refresh deferred CAS fall", cbr_start, 1247);
    chk(cbr_pre >= 3, "R9 RAS precharge before refresh", cbr_pre, 3);
    repeat (10) tick();
  endtask

  task automatic t_access_in_refresh();
    wait_refresh();
    chk(cbr_start == 1866, "R1 refresh from idle clock", cbr_start, 1866);
    host(0, 0, {11'h3FF, 11'h001}, "R8 access after refresh");
    chk(ack_cyc > cbr_end, "R8 no ack during refresh", ack_cyc, cbr_end + 1);
    chk(row_cyc == cbr_end + 3, "R11 direct row open", row_cyc - cbr_end, 3);
    chk(row_addr == 'h3FF, "R11 row address", row_addr, 'h3FF);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    addr = {11'h111, 11'h222}; page_miss = 1; sel_n = 0; wr_n = 0;
    repeat (4) tick();
    @(negedge clk); rst_n = 0; #1;
    chk({ras_n, cas_n, we_n, ack} == 4'b1110, "R2 reset mid access", int'({ras_n, cas_n, we_n, ack}), 14);
    sel_n = 1; wr_n = 1; page_miss = 0;
    repeat (2) tick();
    @(negedge clk); rst_n = 1;
    repeat (2) tick();
  endtask

  initial begin
    t_reset();
    t_first_refresh();
    t_idle_read();
    t_hit_write();
    t_hit_read();
    t_open_hold();
    t_miss_write();
    t_refresh_defer();
    t_access_in_refresh();
    t_reset_mid();
    chk(ack_wide == 0, "R5 ack one clock wide", int'(ack_wide), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule